// File: doc/BRIEF.md
# Read/Write Grouping Command Reorderer

This block sits in a memory command path, between a client that issues commands in program order and the controller that drives the DRAM data bus. Each change of direction on that bus between a read and a write costs idle cycles. The block holds a small window of pending commands and lets the second one go ahead of the first when that keeps the bus in its current direction. An interleaved read/write stream that has backed up behind a stalled output therefore leaves the block as grouped runs of reads and of writes.

The window is one command deep. A command can pass at most one older command, and it never passes an older command to the same address. Both sides use the same valid/ready command stream: a direction bit, an address and write data. Write data travels inside the command entry, so it can never separate from its command. Row open/close ordering, DRAM timing and read data return are handled elsewhere.

Top module: `rw_group_reorder`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1. The direction of the last issued command starts as read.
- R2: When the oldest held command has the same direction as the last issued command, or the younger one does not match that direction, commands leave in the order they were accepted. The direction bit is 0 for a read and 1 for a write.
- R3: Suppose the oldest held command differs in direction from the last issued command, the younger held command matches it, and the addresses differ. Then the younger command is issued first.
- R4: A held read and write to the same address are never swapped. They leave in acceptance order.
- R5: A command that has been passed once is issued next. No command is passed twice.
- R6: Every issued command carries the write data that was accepted with it, whether or not it was swapped.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_we`, `out_addr` and `out_wdata` keep their values.
- R8: The block holds at most three commands: two in the window and one in the output register. `in_ready` is 0 when the window is full, and no accepted command is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Incoming command present |
| in_ready | output | 1 | Block can take a command this cycle |
| in_we | input | 1 | Incoming direction: 0 read, 1 write |
| in_addr | input | ADDR_W | Incoming command address |
| in_wdata | input | DATA_W | Write data travelling with the command |
| out_valid | output | 1 | Issued command present (registered) |
| out_ready | input | 1 | Downstream takes the issued command |
| out_we | output | 1 | Issued direction: 0 read, 1 write |
| out_addr | output | ADDR_W | Issued command address |
| out_wdata | output | DATA_W | Write data of the issued command |

## Verification
A swap only happens when both window slots are full while the output register is busy. With a free-flowing output, every command goes straight through alone, so the stimulus holds `out_ready` low until three commands are parked and then releases it. The limit of one bypass per command needs a further step. The bench releases `out_ready` for exactly one cycle so that a swap takes place, then stalls the output again and feeds a fresh same-direction command that would otherwise pass the already-bypassed head a second time.

// File: rtl/rwr_pkg.sv
package rwr_pkg;
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  localparam int WINDOW_SLOTS = 2;
endpackage

// File: rtl/rwr_pick.sv
module rwr_pick #(
  parameter int ADDR_W = 16
) (
  input  logic              a_valid,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_byp,
  input  logic              b_valid,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              last_we,
  output logic              take_b
);
  logic head_turns;
  logic next_keeps;
  logic hazard;

  always_comb begin
    head_turns = a_valid && (a_we != last_we);
    next_keeps = b_valid && (b_we == last_we);
    hazard     = (a_addr == b_addr);
    take_b     = head_turns && next_keeps && !hazard && !a_byp;
  end
endmodule

// File: rtl/rwr_slots.sv
module rwr_slots #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_we,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_a,
  input  logic              pop_b,
  output logic              a_valid,
  output logic              a_we,
  output logic [ADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0] a_data,
  output logic              a_byp,
  output logic              b_valid,
  output logic              b_we,
  output logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_data
);
  // control state: reset
  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      b_valid <= 1'b0;
      a_byp   <= 1'b0;
    end else if (pop_b) begin
      a_byp   <= 1'b1;
      b_valid <= push;
    end else if (pop_a) begin
      if (b_valid) begin
        a_valid <= 1'b1;
        a_byp   <= 1'b0;
        b_valid <= push;
      end else begin
        a_valid <= push;
        a_byp   <= 1'b0;
      end
    end else if (push) begin
      if (!a_valid) begin
        a_valid <= 1'b1;
        a_byp   <= 1'b0;
      end else begin
        b_valid <= 1'b1;
      end
    end
  end

  // payload: no reset, register-file friendly
  always_ff @(posedge clk) begin
    if (pop_b) begin
      if (push) begin
        b_we   <= push_we;
        b_addr <= push_addr;
        b_data <= push_data;
      end
    end else if (pop_a) begin
      if (b_valid) begin
        a_we   <= b_we;
        a_addr <= b_addr;
        a_data <= b_data;
        if (push) begin
          b_we   <= push_we;
          b_addr <= push_addr;
          b_data <= push_data;
        end
      end else if (push) begin
        a_we   <= push_we;
        a_addr <= push_addr;
        a_data <= push_data;
      end
    end else if (push) begin
      if (!a_valid) begin
        a_we   <= push_we;
        a_addr <= push_addr;
        a_data <= push_data;
      end else begin
        b_we   <= push_we;
        b_addr <= push_addr;
        b_data <= push_data;
      end
    end
  end
endmodule

// File: rtl/rwr_outreg.sv
module rwr_outreg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              out_ready,
  output logic              can_load,
  output logic              last_we,
  output logic              out_valid,
  output logic              out_we,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata
);
  import rwr_pkg::*;

  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      last_we   <= DIR_READ;
    end else if (can_load) begin
      out_valid <= load;
      if (load) last_we <= ld_we;
    end
  end

  always_ff @(posedge clk) begin
    if (can_load && load) begin
      out_we    <= ld_we;
      out_addr  <= ld_addr;
      out_wdata <= ld_data;
    end
  end
endmodule

// File: rtl/rw_group_reorder.sv
module rw_group_reorder #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_we,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_we,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_wdata
);
  logic              a_valid, a_we, a_byp;
  logic              b_valid, b_we;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [DATA_W-1:0] a_data, b_data;
  logic              can_load, last_we, take_b, issue, push;
  logic              sel_we;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_data;

  assign in_ready = !b_valid;
  assign push     = in_valid && in_ready;
  assign issue    = can_load && a_valid;

  always_comb begin
    sel_we   = take_b ? b_we   : a_we;
    sel_addr = take_b ? b_addr : a_addr;
    sel_data = take_b ? b_data : a_data;
  end

  rwr_slots #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst(rst),
    .push(push), .push_we(in_we), .push_addr(in_addr), .push_data(in_wdata),
    .pop_a(issue && !take_b), .pop_b(issue && take_b),
    .a_valid(a_valid), .a_we(a_we), .a_addr(a_addr), .a_data(a_data), .a_byp(a_byp),
    .b_valid(b_valid), .b_we(b_we), .b_addr(b_addr), .b_data(b_data)
  );

  rwr_pick #(.ADDR_W(ADDR_W)) u_pick (
    .a_valid(a_valid), .a_we(a_we), .a_addr(a_addr), .a_byp(a_byp),
    .b_valid(b_valid), .b_we(b_we), .b_addr(b_addr),
    .last_we(last_we), .take_b(take_b)
  );

  rwr_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst),
    .load(issue), .ld_we(sel_we), .ld_addr(sel_addr), .ld_data(sel_data),
    .out_ready(out_ready), .can_load(can_load), .last_we(last_we),
    .out_valid(out_valid), .out_we(out_we), .out_addr(out_addr), .out_wdata(out_wdata)
  );
endmodule

// File: rtl/rw_group_reorder_checker.sv
module rw_group_reorder_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_we,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_wdata,
  input logic              issue,
  input logic              take_b,
  input logic              a_we,
  input logic              b_we,
  input logic              last_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [ADDR_W-1:0] b_addr
);
  logic [2:0] occ;
  logic       in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + {2'b0, in_fire} - {2'b0, out_fire};
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (!out_valid && in_ready));

  assert_swap_turns_R3: assert property (@(posedge clk) disable iff (rst)
    (issue && take_b) |-> (b_we == last_we && a_we != last_we));

  assert_swap_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (issue && take_b) |=> (out_valid && out_addr == $past(b_addr)));

  assert_no_hazard_swap_R4: assert property (@(posedge clk) disable iff (rst)
    (issue && take_b) |-> (a_addr != b_addr));

  assert_bypass_once_R5: assert property (@(posedge clk) disable iff (rst)
    (issue && take_b) |=> !(issue && take_b));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_we) && $stable(out_addr) && $stable(out_wdata)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'd3);
endmodule

bind rw_group_reorder rw_group_reorder_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_we(out_we),
  .out_addr(out_addr), .out_wdata(out_wdata), .issue(issue), .take_b(take_b),
  .a_we(a_we), .b_we(b_we), .last_we(last_we), .a_addr(a_addr), .b_addr(b_addr)
);

// File: tb/rw_group_reorder_test.sv
module rw_group_reorder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 0;
  logic          rst = 1;
  logic          in_valid = 0, in_we = 0, out_ready = 0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_wdata = '0;
  logic          in_ready, out_valid, out_we;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_wdata;

  int n_checks = 0;
  int n_fail   = 0;
  int got_n    = 0;
  logic          got_we   [64];
  logic [AW-1:0] got_addr [64];
  logic [DW-1:0] got_data [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  rw_group_reorder #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_we(out_we),
    .out_addr(out_addr), .out_wdata(out_wdata)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && got_n < 64) begin
      got_we[got_n]   = out_we;
      got_addr[got_n] = out_addr;
      got_data[got_n] = out_wdata;
      got_n = got_n + 1;
    end
  end

  function automatic logic [DW-1:0] data_for(bit we, int addr);
    return we ? (32'hD000_0000 + addr) : 32'h0;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(bit we, int addr);
    in_valid = 1; in_we = we; in_addr = addr[AW-1:0]; in_wdata = data_for(we, addr);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic wait_outputs(int n);
    int t = 0;
    while (got_n < n && t < 200) begin @(posedge clk); #1; t++; end
  endtask

  task automatic expect_out(int idx, bit we, int addr, string req);
    logic [63:0] act, exp;
    act = {15'b0, got_we[idx], got_addr[idx], got_data[idx]};
    exp = {15'b0, we, addr[AW-1:0], data_for(we, addr)};
    check(req, act, exp, $sformatf("output %0d {we,addr,data}", idx));
  endtask

  task automatic start_case();
    out_ready = 0;
    repeat (3) @(posedge clk);
    #1; got_n = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    @(negedge clk);
    check("R1", {63'b0, out_valid}, 64'd0, "out_valid after reset");
    check("R1", {63'b0, in_ready},  64'd1, "in_ready after reset");
  endtask

  task automatic t_stream_in_order();
    start_case();
    out_ready = 1;
    send(0, 10); send(1, 11); send(0, 12); send(1, 13);
    wait_outputs(4);
    check("R2", got_n, 4, "stream count");
    expect_out(0, 0, 10, "R2"); expect_out(1, 1, 11, "R2");
    expect_out(2, 0, 12, "R2"); expect_out(3, 1, 13, "R2");
  endtask

  task automatic t_head_matches();
    // last issued read, head read, next write: order kept (R2)
    start_case();
    send(0, 20); send(0, 21); send(1, 22);
    @(posedge clk); #1; out_ready = 1;
    wait_outputs(3);
    expect_out(0, 0, 20, "R2"); expect_out(1, 0, 21, "R2"); expect_out(2, 1, 22, "R2");
  endtask

  task automatic t_group();
    start_case();
    send(0, 30); send(1, 31); send(0, 32);
    @(negedge clk);
    check("R8", {63'b0, in_ready}, 64'd0, "in_ready with full window");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", {47'b0, out_valid, out_addr}, {47'b0, 1'b1, 16'd30}, "held output");
    end
    @(posedge clk); #1; out_ready = 1;
    send(1, 33);
    wait_outputs(4);
    check("R8", got_n, 4, "grouped count");
    expect_out(0, 0, 30, "R3"); expect_out(1, 0, 32, "R3");
    expect_out(2, 1, 31, "R6"); expect_out(3, 1, 33, "R6");
  endtask

  task automatic t_conflict();
    start_case();
    send(0, 40); send(1, 47); send(0, 47);
    @(posedge clk); #1; out_ready = 1;
    wait_outputs(3);
    expect_out(0, 0, 40, "R4"); expect_out(1, 1, 47, "R4"); expect_out(2, 0, 47, "R4");
  endtask

  task automatic t_bypass_once();
    start_case();
    send(0, 51); send(1, 52); send(0, 53);
    @(posedge clk); #1; out_ready = 1;
    @(posedge clk); #1; out_ready = 0;
    send(0, 54);
    @(posedge clk); #1; out_ready = 1;
    wait_outputs(4);
    expect_out(0, 0, 51, "R3"); expect_out(1, 0, 53, "R3");
    expect_out(2, 1, 52, "R5"); expect_out(3, 0, 54, "R5");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_stream_in_order();
    t_head_matches();
    t_group();
    t_conflict();
    t_bypass_once();
    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule